// File: doc/BRIEF.md
# Registered Two-Plane Logic Array State Machine

This block is a configurable sum-of-products array wrapped in clock-edge registers, so that a single structure can realize any clocked sequential network. Primary inputs and the fed-back state bits are latched together into a capture register. Each captured column reaches a product plane in both polarities, and each product term is the AND of the literals its cells select. A second plane ORs chosen product terms into sums. The sums are latched into a result register that drives the primary outputs and, through feedback, the next state.

The behaviour is programmed entirely through two personality parameters. One gives a two-bit code for each product-plane cell. The other gives one bit for each sum-plane crossing. The two non-overlapping clock phases are modelled on one clock: the capture register loads on the rising edge and the result register loads on the falling edge. An integrator sets the sizes (primary inputs, state bits, product terms, primary outputs) and supplies the two matrices.

Top module: `pla_fsm`

## Requirements
- R1: A product-plane cell code decides how its column enters the term. Code 2'b00 leaves the column out. Code 2'b01 uses the true value. Code 2'b10 uses the complement. Code 2'b11 connects both polarities, which forces the term to 0.
- R2: A product term whose cells all hold code 2'b00 evaluates to 1.
- R3: A sum is the OR of the product terms whose sum-plane bit is 1. A sum with no bits set evaluates to 0.
- R4: On each rising edge the capture register loads the primary inputs and the current state bits. Input changes made after that edge do not affect the result latched at the following falling edge.
- R5: The result register, and with it `dataOut` and `stateOut`, changes only on the falling edge. Both outputs hold their value across the rising edge.
- R6: The state sums latched at a falling edge appear on `stateOut` and are captured as state columns at the next rising edge, which gives clocked next-state behaviour.
- R7: Reset is synchronous and active high. While it is high, the rising edge clears the capture register and the falling edge clears the result register, so `dataOut` and `stateOut` read 0. After release, the result register stays cleared until the capture register has loaded once.
- R8: Column c of the product plane is `dataIn[c]` for c < NUM_IN and state bit c-NUM_IN above that. The cell for term p and column c sits at AND_MAP bits [(p*NUM_COL+c)*2 +: 2]. Sum s is `dataOut[s]` for s < NUM_OUT and next-state bit s-NUM_OUT above that, with term p at OR_MAP bit s*NUM_PT+p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge loads the capture register, falling edge loads the result register |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | NUM_IN | Primary inputs |
| dataOut | output | NUM_OUT | Registered primary outputs |
| stateOut | output | NUM_ST | Registered state bits, also fed back internally |

## Verification
The hardest situation to reach from the ports is the gap between the two register stages. The capture register has to be shown to hold the value from the rising edge while the input pins change before the falling edge. The bench reaches it by driving one vector, letting the rising edge pass, and then overwriting the pins with the complement before the falling edge. The result must then still match the first vector. The stimulus personality realizes an enable-controlled two-bit counter, which drives the feedback through every state and through the wrap from 3 to 0. Alongside it are a constant-one term, a term forced to zero by code 2'b11, and an output with no terms. A generic model of the two planes then follows long random input sequences with a reset inserted mid-run.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    CELL_OMIT = 2'b00,
    CELL_TRUE = 2'b01,
    CELL_COMP = 2'b10,
    CELL_ZERO = 2'b11
  } cell_e;

  typedef struct packed {
    logic clrIn;
    logic clrOut;
  } strobe_t;

endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobes
);

  // Set once the capture register has loaded real data after reset.
  logic primed;

  always_ff @(posedge clk) begin
    primed <= !rst;
  end

  always_comb begin
    strobes.clrIn  = rst;
    strobes.clrOut = rst || !primed;
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int NUM_COL = 5,
  parameter int NUM_PT  = 9,
  parameter logic [NUM_PT*NUM_COL*2-1:0] AND_MAP = '0
) (
  input  logic [NUM_COL-1:0] colIn,
  output logic [NUM_PT-1:0]  termOut
);

  logic [NUM_PT-1:0][NUM_COL-1:0] cellPass;

  for (genvar p = 0; p < NUM_PT; p++) begin : g_term
    for (genvar c = 0; c < NUM_COL; c++) begin : g_cell
      localparam logic [1:0] CODE = AND_MAP[(p*NUM_COL+c)*2 +: 2];
      if (CODE == CELL_TRUE) begin : g_true
        assign cellPass[p][c] = colIn[c];
      end else if (CODE == CELL_COMP) begin : g_comp
        assign cellPass[p][c] = ~colIn[c];
      end else if (CODE == CELL_ZERO) begin : g_zero
        // both polarities connected: x & ~x
        assign cellPass[p][c] = colIn[c] & ~colIn[c];
      end else begin : g_omit
        assign cellPass[p][c] = 1'b1;
      end
    end
    assign termOut[p] = &cellPass[p];
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_PT  = 9,
  parameter int NUM_SUM = 6,
  parameter logic [NUM_SUM*NUM_PT-1:0] OR_MAP = '0
) (
  input  logic [NUM_PT-1:0]  termIn,
  output logic [NUM_SUM-1:0] sumOut
);

  for (genvar s = 0; s < NUM_SUM; s++) begin : g_sum
    localparam logic [NUM_PT-1:0] SEL = OR_MAP[s*NUM_PT +: NUM_PT];
    if (SEL == '0) begin : g_empty
      assign sumOut[s] = 1'b0;
    end else begin : g_wired
      assign sumOut[s] = |(termIn & SEL);
    end
  end

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_ST  = 2,
  parameter int NUM_OUT = 4,
  localparam int NUM_COL = NUM_IN + NUM_ST,
  localparam int NUM_SUM = NUM_OUT + NUM_ST
) (
  input  logic               clk,
  input  strobe_t            strobes,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_SUM-1:0] sumIn,
  output logic [NUM_COL-1:0] capturedIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic [NUM_ST-1:0]  stateOut
);

  logic [NUM_SUM-1:0] resultReg;

  // capture stage: first phase
  always_ff @(posedge clk) begin
    if (strobes.clrIn) capturedIn <= '0;
    else               capturedIn <= {resultReg[NUM_SUM-1:NUM_OUT], dataIn};
  end

  // result stage: second phase
  always_ff @(negedge clk) begin
    if (strobes.clrOut) resultReg <= '0;
    else                resultReg <= sumIn;
  end

  assign dataOut  = resultReg[NUM_OUT-1:0];
  assign stateOut = resultReg[NUM_SUM-1:NUM_OUT];

endmodule

// File: rtl/pla_fsm.sv
module pla_fsm
  import pla_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_ST  = 2,
  parameter int NUM_PT  = 9,
  parameter int NUM_OUT = 4,
  localparam int NUM_COL = NUM_IN + NUM_ST,
  localparam int NUM_SUM = NUM_OUT + NUM_ST,
  // default personality: enable-driven 2-bit counter plus fixed outputs
  parameter logic [NUM_PT*NUM_COL*2-1:0] AND_MAP = {
    10'b00_00_01_10_00, 10'b00_00_10_01_00, 10'b00_00_00_11_00,
    10'b01_10_00_00_00, 10'b01_00_00_00_10, 10'b10_01_00_00_01,
    10'b00_01_00_00_10, 10'b00_10_00_00_01, 10'b00_00_00_00_00},
  parameter logic [NUM_SUM*NUM_PT-1:0] OR_MAP = {
    9'b000111000, 9'b000000110, 9'b110000000,
    9'b000000000, 9'b001000000, 9'b000000001}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic [NUM_ST-1:0]  stateOut
);

  strobe_t            strobes;
  logic [NUM_COL-1:0] capturedIn;
  logic [NUM_PT-1:0]  terms;
  logic [NUM_SUM-1:0] sums;

  pla_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  pla_and_plane #(
    .NUM_COL (NUM_COL),
    .NUM_PT  (NUM_PT),
    .AND_MAP (AND_MAP)
  ) u_and (
    .colIn   (capturedIn),
    .termOut (terms)
  );

  pla_or_plane #(
    .NUM_PT  (NUM_PT),
    .NUM_SUM (NUM_SUM),
    .OR_MAP  (OR_MAP)
  ) u_or (
    .termIn (terms),
    .sumOut (sums)
  );

  pla_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_ST  (NUM_ST),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .dataIn     (dataIn),
    .sumIn      (sums),
    .capturedIn (capturedIn),
    .dataOut    (dataOut),
    .stateOut   (stateOut)
  );

endmodule

// File: rtl/pla_fsm_chk.sv
module pla_fsm_chk #(
  parameter int NUM_IN  = 3,
  parameter int NUM_ST  = 2,
  parameter int NUM_PT  = 9,
  parameter int NUM_OUT = 4,
  localparam int NUM_COL = NUM_IN + NUM_ST,
  localparam int NUM_SUM = NUM_OUT + NUM_ST,
  parameter logic [NUM_PT*NUM_COL*2-1:0] AND_MAP = '0,
  parameter logic [NUM_SUM*NUM_PT-1:0]   OR_MAP  = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IN-1:0]  dataIn,
  input logic [NUM_OUT-1:0] dataOut,
  input logic [NUM_ST-1:0]  stateOut,
  input logic [NUM_COL-1:0] capturedIn
);

  function automatic logic [NUM_OUT-1:0] deadOutputs();
    logic [NUM_OUT-1:0] m;
    for (int s = 0; s < NUM_OUT; s++) m[s] = (OR_MAP[s*NUM_PT +: NUM_PT] == '0);
    return m;
  endfunction

  function automatic logic [NUM_OUT-1:0] oneOutputs();
    logic [NUM_OUT-1:0] m;
    for (int s = 0; s < NUM_OUT; s++) begin
      m[s] = 1'b0;
      for (int p = 0; p < NUM_PT; p++)
        if (OR_MAP[s*NUM_PT+p] && AND_MAP[p*NUM_COL*2 +: NUM_COL*2] == '0) m[s] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NUM_OUT-1:0] DEAD_MASK = deadOutputs();
  localparam logic [NUM_OUT-1:0] ONE_MASK  = oneOutputs();

  // R7: reset seen at a falling edge leaves both output buses cleared
  a_r7_out_cleared: assert property (@(negedge clk)
    rst |=> (dataOut == '0 && stateOut == '0));

  // R7: reset seen at a rising edge empties the capture register
  a_r7_capture_cleared: assert property (@(posedge clk)
    rst |=> capturedIn == '0);

  // R4: capture register holds the inputs and state present at the last rising edge
  a_r4_capture_load: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> capturedIn == $past({stateOut, dataIn}));

  // R3: outputs with no connected term stay low
  a_r3_empty_sum_low: assert property (@(negedge clk) disable iff (rst)
    (dataOut & DEAD_MASK) == '0);

  // R2: outputs fed by an all-omit term read 1 once running
  a_r2_const_term_high: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |=> (dataOut & ONE_MASK) == ONE_MASK);

endmodule

bind pla_fsm pla_fsm_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_ST  (NUM_ST),
  .NUM_PT  (NUM_PT),
  .NUM_OUT (NUM_OUT),
  .AND_MAP (AND_MAP),
  .OR_MAP  (OR_MAP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dataIn     (dataIn),
  .dataOut    (dataOut),
  .stateOut   (stateOut),
  .capturedIn (capturedIn)
);

// File: tb/pla_fsm_bench.sv
module pla_fsm_bench;

  localparam int NUM_IN  = 3;
  localparam int NUM_ST  = 2;
  localparam int NUM_PT  = 9;
  localparam int NUM_OUT = 4;
  localparam int NUM_COL = NUM_IN + NUM_ST;
  localparam int NUM_SUM = NUM_OUT + NUM_ST;

  // cells per term, columns {s1,s0,in2,in1,in0}; 00 omit 01 true 10 comp 11 zero
  localparam logic [NUM_PT*NUM_COL*2-1:0] B_AND = {
    10'b00_00_01_10_00,  // t8: ~in1 & in2
    10'b00_00_10_01_00,  // t7: in1 & ~in2
    10'b00_00_00_11_00,  // t6: forced zero
    10'b01_10_00_00_00,  // t5: s1 & ~s0
    10'b01_00_00_00_10,  // t4: s1 & ~in0
    10'b10_01_00_00_01,  // t3: ~s1 & s0 & in0
    10'b00_01_00_00_10,  // t2: s0 & ~in0
    10'b00_10_00_00_01,  // t1: ~s0 & in0
    10'b00_00_00_00_00}; // t0: constant one
  localparam logic [NUM_SUM*NUM_PT-1:0] B_OR = {
    9'b000111000,  // next s1
    9'b000000110,  // next s0
    9'b110000000,  // o3 = in1 ^ in2
    9'b000000000,  // o2 empty
    9'b001000000,  // o1 forced-zero term
    9'b000000001}; // o0 constant term

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IN-1:0]  dataIn = '0;
  logic [NUM_OUT-1:0] dataOut;
  logic [NUM_ST-1:0]  stateOut;

  int total = 0;
  int bad   = 0;
  logic [NUM_ST-1:0] modelState;

  always #5 clk = ~clk;

  pla_fsm #(
    .NUM_IN (NUM_IN), .NUM_ST (NUM_ST), .NUM_PT (NUM_PT), .NUM_OUT (NUM_OUT),
    .AND_MAP (B_AND), .OR_MAP (B_OR)
  ) u_pla_fsm (
    .clk (clk), .rst (rst), .dataIn (dataIn), .dataOut (dataOut), .stateOut (stateOut)
  );

  // {in[2:0], expected out[3:0], expected state[1:0]}
  localparam logic [8:0] VEC [8] = '{
    {3'b001, 4'b0001, 2'd1},
    {3'b011, 4'b1001, 2'd2},
    {3'b000, 4'b0001, 2'd2},
    {3'b101, 4'b1001, 2'd3},
    {3'b111, 4'b0001, 2'd0},
    {3'b110, 4'b0001, 2'd0},
    {3'b011, 4'b1001, 2'd1},
    {3'b010, 4'b1001, 2'd1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // generic two-plane model
  function automatic logic [NUM_SUM-1:0] model(input logic [NUM_COL-1:0] col);
    logic [NUM_PT-1:0]  t;
    logic [NUM_SUM-1:0] s;
    for (int p = 0; p < NUM_PT; p++) begin
      t[p] = 1'b1;
      for (int c = 0; c < NUM_COL; c++) begin
        case (B_AND[(p*NUM_COL+c)*2 +: 2])
          2'b01:   t[p] = t[p] & col[c];
          2'b10:   t[p] = t[p] & ~col[c];
          2'b11:   t[p] = 1'b0;
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NUM_SUM; k++) s[k] = |(t & B_OR[k*NUM_PT +: NUM_PT]);
    return s;
  endfunction

  // called at falling edge + 2 ns; ends at falling edge + 2 ns one cycle later
  task automatic step(input logic [NUM_IN-1:0] v);
    dataIn = v;
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R7 reset dataOut", 32'(dataOut), 0);
    chk("R7 reset stateOut", 32'(stateOut), 0);
    rst = 1'b0;

    // table walk: counter, constant, forced-zero, empty and xor outputs
    foreach (VEC[i]) begin
      logic [NUM_OUT-1:0] prevOut;
      prevOut = dataOut;
      dataIn = VEC[i][8:6];
      @(posedge clk);
      #1;
      chk("R5 hold across rising edge", 32'(dataOut), 32'(prevOut));
      @(negedge clk);
      #2;
      chk("R6 R8 table dataOut", 32'(dataOut), 32'(VEC[i][5:2]));
      chk("R6 table stateOut", 32'(stateOut), 32'(VEC[i][1:0]));
      chk("R2 constant term", 32'(dataOut[0]), 1);
      chk("R1 code 11 term", 32'(dataOut[1]), 0);
      chk("R3 empty sum", 32'(dataOut[2]), 0);
    end
    modelState = 2'd1;

    // R4: pins change after the rising edge; result follows the captured value
    dataIn = 3'b011;
    @(posedge clk);
    #1 dataIn = 3'b100;
    @(negedge clk);
    #2;
    chk("R4 late change ignored dataOut", 32'(dataOut), 32'b1001);
    chk("R4 late change ignored stateOut", 32'(stateOut), 2);
    modelState = 2'd2;

    // R1: each code on in0 (true/comp via counter enable); state 2 hold with in0=0
    step(3'b000);
    chk("R1 complement literal", 32'(stateOut), 2);

    // R7: mid-run reset
    rst = 1'b1;
    step(3'b111);
    chk("R7 mid-run dataOut", 32'(dataOut), 0);
    chk("R7 mid-run stateOut", 32'(stateOut), 0);
    rst = 1'b0;
    modelState = '0;

    // random sequences against the model, R6 feedback
    for (int n = 0; n < 400; n++) begin
      logic [NUM_IN-1:0]  v;
      logic [NUM_SUM-1:0] e;
      v = NUM_IN'($urandom);
      e = model({modelState, v});
      step(v);
      chk("R6 random dataOut", 32'(dataOut), 32'(e[NUM_OUT-1:0]));
      chk("R6 random stateOut", 32'(stateOut), 32'(e[NUM_SUM-1:NUM_OUT]));
      modelState = e[NUM_SUM-1:NUM_OUT];
      if (n == 200) begin
        rst = 1'b1;
        step(v);
        chk("R7 random reset", 32'({stateOut, dataOut}), 0);
        rst = 1'b0;
        modelState = '0;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule